// File: doc/BRIEF.md
# Two-Level Short-Descriptor Table Walker

This block resolves a 32-bit virtual address into a 32-bit physical address by reading descriptors from a two-level translation table held in memory. A client hands over a virtual address and the base of the root table. The walker then fetches one descriptor, or two when the first one points to a second-level table. It reports the translated address together with the decoded permission and memory-type attributes. When it meets an empty entry, it reports a fault instead.

The walker accepts four leaf sizes. At the first level it handles 1 MB and 16 MB leaves; at the second level it handles 4 KB and 64 KB leaves. The bit positions of the attribute group and the execute-never flag depend on the level and on the leaf size. Only one walk runs at a time. Descriptor reads use a request/accept handshake followed by a separate data-return strobe, and either phase may stall for any number of cycles.

Top module: `sdesc_walker`

## Requirements
- R1: `req_ready` is high only while no walk is running. A request is taken on a cycle where `req_valid` and `req_ready` are both high. A `req_valid` raised during a walk is ignored and does not change that walk's result.
- R2: The first read address is `root_base + va[31:20]*4`. After a table pointer, the second read address is `{entry[31:10], 10'b0} + va[19:12]*4`.
- R3: A descriptor whose bits 1:0 are 00 ends the walk with `rsp_fault` high, at either level. On a fault, `rsp_pa` and all attribute outputs are 0.
- R4: A first-level descriptor with bits 1:0 = 01 is a table pointer and causes exactly one second-level read. Any other valid first-level code (10 or 11) is a leaf and causes no second read.
- R5: For a first-level leaf with bit 18 clear, `rsp_pa = {entry[31:20], va[19:0]}`.
- R6: For a first-level leaf with bit 18 set, `rsp_pa = {entry[31:24], va[23:0]}`.
- R7: A second-level descriptor with bit 1 set is a 4 KB page: `rsp_pa = {entry[31:12], va[11:0]}`. Its execute-never flag is entry bit 0 and its TEX is entry bits 8:6.
- R8: A second-level descriptor with bits 1:0 = 01 is a 64 KB page: `rsp_pa = {entry[31:16], va[15:0]}`. Its execute-never flag is entry bit 15 and its TEX is entry bits 14:12.
- R9: The attribute group is entry bits 17:10 for a first-level leaf and entry bits 11:4 for a second-level leaf. `rsp_wr_ok` is the inverse of group bit 5, and `rsp_user_ok` is group bit 1.
- R10: For a first-level leaf, `rsp_xn` is entry bit 4.
- R11: `rsp_device` is high when TEX is 000. `rsp_cached` is high when TEX is not 000 and entry bit 3 is set. For first-level leaves and 4 KB pages, TEX is group bits 4:2.
- R12: The memory port tolerates any delay before `mem_rd_ready` and any delay before `mem_rsp_valid`. `mem_rd_valid` and `mem_rd_addr` stay steady until the read is accepted.
- R13: `rsp_done` is a one-cycle pulse. It rises in the cycle after the `mem_rsp_valid` that carries the final descriptor of the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address to translate |
| root_base | input | 32 | Byte address of the first-level table |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data is present |
| mem_rsp_data | input | 32 | Descriptor word |
| rsp_done | output | 1 | Walk complete pulse |
| rsp_fault | output | 1 | Walk ended on an invalid descriptor |
| rsp_pa | output | 32 | Translated physical address |
| rsp_wr_ok | output | 1 | Writes permitted |
| rsp_user_ok | output | 1 | Unprivileged access permitted |
| rsp_xn | output | 1 | Execute-never |
| rsp_device | output | 1 | Device memory type |
| rsp_cached | output | 1 | Cacheable normal memory |

## Verification
Directed walks cover the following cases:
- a 1 MB leaf and a 16 MB leaf, which show whether the output mask widens;
- a first-level entry with code 11, which must be taken as a leaf and not as a table;
- 4 KB and 64 KB second-level pages, whose execute-never and TEX fields sit in different places;
- empty entries at each level, which must fault.

The 64 KB case sets the group's TEX bits and clears the relocated TEX field, so a decoder that reads the wrong field gives the wrong memory type.

A few hundred random walks then draw random descriptors of every kind, with random memory wait states at both handshake phases. On each walk the bench compares the read addresses, the number of reads, the timing of the done pulse and every response field. It also raises a stray request during each walk to show that the stray request is refused.

// File: rtl/walk_pkg.sv
package walk_pkg;

    localparam int ADDR_W     = 32;
    localparam int L1_IDX_W   = 12;
    localparam int L2_IDX_W   = 8;
    localparam int OFF_W      = ADDR_W - L1_IDX_W - L2_IDX_W;
    localparam int DESC_LOG2  = 2;
    localparam int TBL_ALIGN  = 10;
    localparam int GRP_W      = 8;

    // descriptor field positions
    localparam int L1_GRP_LSB    = 10;
    localparam int L2_GRP_LSB    = 4;
    localparam int L1_XN_BIT     = 4;
    localparam int SMALL_XN_BIT  = 0;
    localparam int LARGE_XN_BIT  = 15;
    localparam int LARGE_TEX_LSB = 12;
    localparam int SUPER_BIT     = 18;
    localparam int CACHE_BIT     = 3;

    // mask shift per leaf kind
    localparam int SH_SECTION = ADDR_W - L1_IDX_W;
    localparam int SH_SUPER   = SH_SECTION + 4;
    localparam int SH_SMALL   = OFF_W;
    localparam int SH_LARGE   = OFF_W + 4;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_ISSUE, ST_L1_WAIT, ST_L2_ISSUE, ST_L2_WAIT
    } walk_st_e;

    typedef enum logic [1:0] {
        KIND_FAULT, KIND_TABLE, KIND_LEAF
    } kind_e;

    typedef struct packed {
        logic wr_ok;
        logic user_ok;
        logic xn;
        logic device;
        logic cached;
    } attr_t;

    typedef struct packed {
        kind_e kind;
        addr_t pa;
        attr_t attr;
        addr_t next_base;
    } dec_t;

    function automatic addr_t l1_desc_addr(input addr_t root, input addr_t va);
        addr_t ofs;
        ofs = '0;
        ofs[DESC_LOG2 +: L1_IDX_W] = va[ADDR_W-1 -: L1_IDX_W];
        return root + ofs;
    endfunction

    function automatic addr_t l2_desc_addr(input addr_t base, input addr_t va);
        addr_t ofs;
        ofs = '0;
        ofs[DESC_LOG2 +: L2_IDX_W] = va[OFF_W +: L2_IDX_W];
        return base + ofs;
    endfunction

endpackage

// File: rtl/walk_decode.sv
module walk_decode
    import walk_pkg::*;
(
    input  addr_t entry,
    input  logic  at_l2,
    input  addr_t va,
    output dec_t  dec
);

    logic [GRP_W-1:0] grp;
    logic [2:0]       tex;
    logic             xn;
    logic [4:0]       sh;
    addr_t            keep;

    always_comb begin
        grp = entry[L1_GRP_LSB +: GRP_W];
        xn  = entry[L1_XN_BIT];
        sh  = entry[SUPER_BIT] ? 5'(SH_SUPER) : 5'(SH_SECTION);
        if (at_l2) begin
            grp = entry[L2_GRP_LSB +: GRP_W];
            if (entry[1]) begin
                sh = 5'(SH_SMALL);
                xn = entry[SMALL_XN_BIT];
            end else begin
                sh = 5'(SH_LARGE);
                xn = entry[LARGE_XN_BIT];
            end
        end
        tex = (at_l2 && !entry[1]) ? entry[LARGE_TEX_LSB +: 3] : grp[4:2];
        keep = {ADDR_W{1'b1}} << sh;

        dec = '0;
        if (entry[1:0] == 2'b00) begin
            dec.kind = KIND_FAULT;
        end else if (!at_l2 && entry[1:0] == 2'b01) begin
            dec.kind      = KIND_TABLE;
            dec.next_base = {entry[ADDR_W-1:TBL_ALIGN], {TBL_ALIGN{1'b0}}};
        end else begin
            dec.kind         = KIND_LEAF;
            dec.pa           = (entry & keep) | (va & ~keep);
            dec.attr.wr_ok   = ~grp[5];
            dec.attr.user_ok = grp[1];
            dec.attr.xn      = xn;
            dec.attr.device  = (tex == 3'b000);
            dec.attr.cached  = (tex != 3'b000) && entry[CACHE_BIT];
        end
    end

endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
    import walk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    output logic  req_ready,
    input  addr_t req_va,
    input  addr_t root_base,
    output logic  mem_rd_valid,
    input  logic  mem_rd_ready,
    output addr_t mem_rd_addr,
    input  logic  mem_rsp_valid,
    input  dec_t  dec,
    output logic  at_l2,
    output addr_t va_q,
    output logic  rsp_done,
    output logic  rsp_fault,
    output addr_t rsp_pa,
    output attr_t rsp_attr
);

    walk_st_e st;
    addr_t    root_q;
    addr_t    l2_base_q;

    assign req_ready    = (st == ST_IDLE);
    assign mem_rd_valid = (st == ST_L1_ISSUE) || (st == ST_L2_ISSUE);
    assign at_l2        = (st == ST_L2_WAIT);
    assign mem_rd_addr  = (st == ST_L2_ISSUE) ? l2_desc_addr(l2_base_q, va_q)
                                              : l1_desc_addr(root_q, va_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            va_q      <= '0;
            root_q    <= '0;
            l2_base_q <= '0;
            rsp_done  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pa    <= '0;
            rsp_attr  <= '0;
        end else begin
            rsp_done <= 1'b0;
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_va;
                    root_q <= root_base;
                    st     <= ST_L1_ISSUE;
                end
                ST_L1_ISSUE: if (mem_rd_ready) st <= ST_L1_WAIT;
                ST_L2_ISSUE: if (mem_rd_ready) st <= ST_L2_WAIT;
                ST_L1_WAIT, ST_L2_WAIT: if (mem_rsp_valid) begin
                    if (dec.kind == KIND_TABLE) begin
                        l2_base_q <= dec.next_base;
                        st        <= ST_L2_ISSUE;
                    end else begin
                        rsp_done  <= 1'b1;
                        rsp_fault <= (dec.kind == KIND_FAULT);
                        rsp_pa    <= (dec.kind == KIND_FAULT) ? '0 : dec.pa;
                        rsp_attr  <= (dec.kind == KIND_FAULT) ? '0 : dec.attr;
                        st        <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1
    busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> !req_ready);

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R13
    done_after_data_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(mem_rsp_valid));

    // R3
    fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_fault) |-> (rsp_pa == '0 && rsp_attr == '0));

    // R11
    type_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> !(rsp_attr.device && rsp_attr.cached));

endmodule

// File: rtl/sdesc_walker.sv
module sdesc_walker
    import walk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    input  logic [ADDR_W-1:0] root_base,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              rsp_done,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic              rsp_wr_ok,
    output logic              rsp_user_ok,
    output logic              rsp_xn,
    output logic              rsp_device,
    output logic              rsp_cached
);

    dec_t  dec;
    logic  at_l2;
    addr_t va_q;
    attr_t attr;

    walk_decode u_decode (
        .entry (mem_rsp_data),
        .at_l2 (at_l2),
        .va    (va_q),
        .dec   (dec)
    );

    walk_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .root_base     (root_base),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .dec           (dec),
        .at_l2         (at_l2),
        .va_q          (va_q),
        .rsp_done      (rsp_done),
        .rsp_fault     (rsp_fault),
        .rsp_pa        (rsp_pa),
        .rsp_attr      (attr)
    );

    assign rsp_wr_ok   = attr.wr_ok;
    assign rsp_user_ok = attr.user_ok;
    assign rsp_xn      = attr.xn;
    assign rsp_device  = attr.device;
    assign rsp_cached  = attr.cached;

endmodule

// File: tb/test_sdesc_walker.sv
`timescale 1ns/1ps
module test_sdesc_walker;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready;
    logic [31:0] req_va, root_base;
    logic        mem_rd_valid, mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        rsp_done, rsp_fault, rsp_wr_ok, rsp_user_ok, rsp_xn, rsp_device, rsp_cached;
    logic [31:0] rsp_pa;

    always #2.5 clk = ~clk;

    sdesc_walker i_sdesc_walker (.*);

    logic [31:0] mem [logic [31:0]];
    int          n_chk = 0;
    int          n_bad = 0;
    int unsigned cyc = 0;
    int unsigned last_rsp_cyc = 0;
    logic [31:0] rd_log [2];
    int          rd_cnt = 0;
    int          wmax = 0;

    localparam logic [31:0] ROOT = 32'h0010_0000;
    localparam logic [31:0] L2RG = 32'h0020_0000;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // descriptor builders
    function automatic logic [31:0] mk_sec(input logic [11:0] b, input logic sup, input logic [7:0] g,
                                           input logic x, input logic c, input logic code3);
        return {b, 1'b0, sup, g, 5'b0, x, c, 1'b0, 1'b1, code3};
    endfunction
    function automatic logic [31:0] mk_tbl(input logic [21:0] b);
        return {b, 8'b0, 2'b01};
    endfunction
    function automatic logic [31:0] mk_small(input logic [19:0] b, input logic [7:0] g, input logic x, input logic c);
        return {b, g, c, 1'b0, 1'b1, x};
    endfunction
    function automatic logic [31:0] mk_large(input logic [15:0] b, input logic x, input logic [2:0] t,
                                             input logic [7:0] g, input logic c);
        return {b, x, t, g, c, 1'b0, 2'b01};
    endfunction

    // reference walk from the requirements
    task automatic model(input logic [31:0] va, input logic [31:0] root,
                         output logic f, output logic [31:0] pa, output logic [4:0] at,
                         output logic [31:0] a1, output logic [31:0] a2, output logic tb);
        logic [31:0] e;
        logic [7:0]  g;
        logic [2:0]  t;
        logic        x;
        f = 0; pa = 0; at = 0; tb = 0; a2 = 0;
        a1 = root + {18'b0, va[31:20], 2'b00};
        e  = rd(a1);
        if (e[1:0] == 2'b00) begin f = 1; return; end
        if (e[1:0] == 2'b01) begin
            tb = 1;
            a2 = {e[31:10], 10'b0} + {22'b0, va[19:12], 2'b00};
            e  = rd(a2);
            if (e[1:0] == 2'b00) begin f = 1; return; end
            g = e[11:4];
            if (e[1]) begin pa = {e[31:12], va[11:0]}; x = e[0];  t = g[4:2]; end
            else      begin pa = {e[31:16], va[15:0]}; x = e[15]; t = e[14:12]; end
        end else begin
            g = e[17:10]; x = e[4]; t = g[4:2];
            pa = e[18] ? {e[31:24], va[23:0]} : {e[31:20], va[19:0]};
        end
        at = {~g[5], g[1], x, (t == 3'b000), (t != 3'b000) && e[3]};
    endtask

    // memory responder with random waits
    initial begin
        logic [31:0] a0;
        int d;
        mem_rd_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (mem_rd_valid && !rst) begin
                a0 = mem_rd_addr;
                d = $urandom_range(0, wmax);
                repeat (d) @(negedge clk);
                // R12 address steady while waiting for accept
                chk(mem_rd_valid && mem_rd_addr == a0, "R12", mem_rd_addr, a0);
                mem_rd_ready = 1;
                @(negedge clk);
                mem_rd_ready = 0;
                if (rd_cnt < 2) rd_log[rd_cnt] = a0;
                rd_cnt++;
                d = $urandom_range(0, wmax);
                repeat (d) @(negedge clk);
                mem_rsp_data  = rd(a0);
                mem_rsp_valid = 1;
                last_rsp_cyc  = cyc;
            end
        end
    end

    task automatic walk(input logic [31:0] va, input string tag);
        logic        ef, tb;
        logic [31:0] ep, a1, a2;
        logic [4:0]  ea, ga;
        int          n;
        model(va, ROOT, ef, ep, ea, a1, a2, tb);
        rd_cnt = 0;
        @(negedge clk);
        chk(req_ready, "R1 ready idle", 32'(req_ready), 1);
        req_va = va; root_base = ROOT; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        // R1 stray request while busy must be ignored
        chk(!req_ready, "R1 busy", 32'(req_ready), 0);
        req_valid = 1; req_va = ~va; root_base = ~ROOT;
        @(negedge clk);
        req_valid = 0;
        n = 0;
        while (!rsp_done && n < 2000) begin @(negedge clk); n++; end
        chk(rsp_done, {"R13 done ", tag}, 32'(rsp_done), 1);
        chk(cyc == last_rsp_cyc + 1, "R13 timing", cyc, last_rsp_cyc + 1);
        chk(rsp_fault == ef, {"R3 fault ", tag}, 32'(rsp_fault), 32'(ef));
        chk(rsp_pa == ep, {"R5 R6 R7 R8 pa ", tag}, rsp_pa, ep);
        ga = {rsp_wr_ok, rsp_user_ok, rsp_xn, rsp_device, rsp_cached};
        chk(ga == ea, {"R9 R10 R11 attr ", tag}, 32'(ga), 32'(ea));
        chk(rd_cnt == (tb ? 2 : 1), {"R4 reads ", tag}, rd_cnt, tb ? 2 : 1);
        chk(rd_log[0] == a1, "R2 l1 addr", rd_log[0], a1);
        if (tb) chk(rd_log[1] == a2, "R2 l2 addr", rd_log[1], a2);
        @(negedge clk);
        chk(!rsp_done, "R13 pulse", 32'(rsp_done), 0);
    endtask

    function automatic logic [31:0] l1a(input logic [31:0] va);
        return ROOT + {18'b0, va[31:20], 2'b00};
    endfunction
    function automatic logic [31:0] l2a(input logic [21:0] tb, input logic [31:0] va);
        return {tb, 10'b0} + {22'b0, va[19:12], 2'b00};
    endfunction

    initial begin
        logic [31:0] va, e;
        logic [21:0] tb;
        void'($urandom(32'd1234));
        rst = 1; req_valid = 0; req_va = 0; root_base = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready, "R1 reset ready", 32'(req_ready), 1);
        chk(!rsp_done, "R13 reset done", 32'(rsp_done), 0);
        chk(!mem_rd_valid, "R12 reset rd", 32'(mem_rd_valid), 0);

        // R5 1 MB leaf, code 10
        va = 32'h1234_5678;
        mem[l1a(va)] = mk_sec(12'hABC, 0, 8'b0000_0111, 1, 1, 0);
        walk(va, "R5 section");
        // R6 16 MB leaf, read-only, device
        va = 32'h4567_89AB;
        mem[l1a(va)] = mk_sec(12'h9F3, 1, 8'b0010_0001, 0, 1, 0);
        walk(va, "R6 super");
        // R4 code 11 is a leaf
        va = 32'h7700_1234;
        mem[l1a(va)] = mk_sec(12'h155, 0, 8'b0000_1011, 1, 0, 1);
        walk(va, "R4 code11");
        // R3 empty first level
        walk(32'hDEAD_BEEF, "R3 l1");
        // R7 4 KB page
        va = 32'h0803_4567; tb = 22'(L2RG >> 10);
        mem[l1a(va)] = mk_tbl(tb);
        mem[l2a(tb, va)] = mk_small(20'hFEDCB, 8'b0000_0101, 1, 1);
        walk(va, "R7 small");
        // R8 64 KB page: relocated TEX zero while group TEX bits set
        va = 32'h0805_9ABC;
        mem[l2a(tb, va)] = mk_large(16'h4321, 1, 3'b000, 8'b0001_1100, 1);
        walk(va, "R8 large dev");
        va = 32'h0806_1111;
        mem[l2a(tb, va)] = mk_large(16'h8765, 0, 3'b101, 8'b0010_0010, 1);
        walk(va, "R8 large cached");
        // R3 empty second level
        walk(32'h0807_0000, "R3 l2");

        // random walks with wait states
        for (int i = 0; i < 300; i++) begin
            wmax = (i % 3 == 0) ? 0 : 4;
            va = $urandom;
            e  = $urandom;
            case ($urandom_range(0, 4))
                0: mem[l1a(va)] = 32'h0;
                1, 2: mem[l1a(va)] = {e[31:2], 1'b1, e[0]};
                default: begin
                    tb = 22'((L2RG >> 10) + 32'($urandom_range(1, 200)));
                    mem[l1a(va)] = {tb, e[9:2], 2'b01};
                    e = $urandom;
                    if ($urandom_range(0, 7) == 0) e[1:0] = 2'b00;
                    mem[l2a(tb, va)] = e;
                end
            endcase
            walk(va, "random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        n_chk++; n_bad++;
        $display("FAIL R13 watchdog actual=%0d expected=done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule